// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steps a microcoded controller through its 512-word control store. It holds the microprogram counter, reads the microword at that counter in the same cycle, and presents the word to the datapath. The control fields of that word select the next microaddress. The selection never adds an offset. It substitutes bits into the stored 9-bit address field. A two-way branch overwrites the lowest bit with one chosen ALU flag. A sixteen-way dispatch overwrites the lowest four bits with either half of the instruction register.

A stall input freezes the counter, for example while a memory access is still in progress. A microword with its halt bit set stops the sequencer, and it stays stopped until reset. The control store is filled through a plain synchronous write port. The datapath payload bits of each word pass through untouched. Every pin is a plain control or status signal: the block has no streaming interface, so no valid/ready back-pressure rules apply.

Stored microword layout (38 bits):
- bit 37: halt
- bits 36:35: flag select
- bits 34:33: sequencing mode
- bits 32:24: next-address field
- bits 23:0: datapath payload

Top module: `useq_core`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 and `halted` is 0. Execution after reset starts at microaddress 0.
- R2: In mode 0 (bits 34:33 = 00), the next `upc` is the 9-bit next-address field unchanged. The flags and the instruction register have no effect on it.
- R3: In mode 1, the next `upc` is bits 32:25 of the word with the LSB replaced by one flag of `alu_nzvc` (bit 3 = N, 2 = Z, 1 = V, 0 = C). The flag select picks 0 for N, 1 for Z, 2 for V and 3 for C.
- R4: In mode 2, the next `upc` is address-field bits 8:4 followed by `ir[7:4]`.
- R5: In mode 3, the next `upc` is address-field bits 8:4 followed by `ir[3:0]`.
- R6: While `stall` is high at a rising edge, `upc` and `halted` keep their values.
- R7: When the current word has bit 37 set and `stall` is low, `upc` does not advance and `halted` goes high at that edge. `halted` then stays high and `upc` stays frozen until reset, even if the store is rewritten.
- R8: `uword` always equals the stored word at address `upc`. A write becomes visible after the rising edge on which `cs_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Holds the counter and halt state for this edge |
| alu_nzvc | input | 4 | ALU test bits N,Z,V,C (bit 3 down to 0) |
| ir | input | 8 | Instruction register used for dispatch |
| cs_we | input | 1 | Control store write enable |
| cs_waddr | input | 9 | Control store write address |
| cs_wdata | input | 38 | Control store write data |
| upc | output | 9 | Current microprogram counter |
| uword | output | 38 | Microword at `upc` |
| halted | output | 1 | Sticky halt indication |

## Verification
The properties compare `upc` one edge later against the sampled word fields and inputs. They therefore assume that the store location at `upc` holds defined bits after reset, and that `stall`, `alu_nzvc` and `ir` are stable around the edge. The stimulus fills all 512 locations during reset and changes inputs only on the falling edge. Rewrites of the location being executed are done under stall, or after halt, so each edge sees a single well-defined word.

// File: rtl/useq_pkg.sv
package useq_pkg;
  parameter int UA_W  = 9;
  parameter int PAY_W = 24;
  parameter int IR_W  = 8;
  parameter int NIB_W = 4;
  parameter int FLG_W = 4;

  localparam int MODE_W = 2;
  localparam int TSEL_W = 2;
  localparam int CTL_W  = 1 + TSEL_W + MODE_W + UA_W;
  localparam int UW_W   = CTL_W + PAY_W;
  localparam int DEPTH  = 1 << UA_W;

  typedef enum logic [MODE_W-1:0] {
    SEQ_JUMP = 2'd0,
    SEQ_FLAG = 2'd1,
    SEQ_OPHI = 2'd2,
    SEQ_OPLO = 2'd3
  } seq_mode_e;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 9,
  parameter int DW = 38
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int N = 1 << AW;

  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic [UA_W-1:0]   field,
  input  logic [MODE_W-1:0] mode,
  input  logic [TSEL_W-1:0] tsel,
  input  logic [FLG_W-1:0]  nzvc,
  input  logic [IR_W-1:0]   ir,
  output logic [UA_W-1:0]   next_addr
);
  logic test_bit;

  // flag select: 0 -> N (bit 3) ... 3 -> C (bit 0)
  always_comb begin
    case (tsel)
      2'd0:    test_bit = nzvc[3];
      2'd1:    test_bit = nzvc[2];
      2'd2:    test_bit = nzvc[1];
      default: test_bit = nzvc[0];
    endcase
  end

  always_comb begin
    case (seq_mode_e'(mode))
      SEQ_FLAG: next_addr = {field[UA_W-1:1], test_bit};
      SEQ_OPHI: next_addr = {field[UA_W-1:NIB_W], ir[IR_W-1 -: NIB_W]};
      SEQ_OPLO: next_addr = {field[UA_W-1:NIB_W], ir[NIB_W-1:0]};
      default:  next_addr = field;
    endcase
  end
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic [FLG_W-1:0] alu_nzvc,
  input  logic [IR_W-1:0]  ir,
  input  logic             cs_we,
  input  logic [UA_W-1:0]  cs_waddr,
  input  logic [UW_W-1:0]  cs_wdata,
  output logic [UA_W-1:0]  upc,
  output logic [UW_W-1:0]  uword,
  output logic             halted
);
  logic              f_halt;
  logic [TSEL_W-1:0] f_tsel;
  logic [MODE_W-1:0] f_mode;
  logic [UA_W-1:0]   f_next;
  logic [UA_W-1:0]   nxt_addr;
  logic              advance;

  useq_store #(.AW(UA_W), .DW(UW_W)) u_store (
    .clk   (clk),
    .we    (cs_we),
    .waddr (cs_waddr),
    .wdata (cs_wdata),
    .raddr (upc),
    .rdata (uword)
  );

  assign {f_halt, f_tsel, f_mode, f_next} = uword[UW_W-1:PAY_W];

  useq_next u_next (
    .field     (f_next),
    .mode      (f_mode),
    .tsel      (f_tsel),
    .nzvc      (alu_nzvc),
    .ir        (ir),
    .next_addr (nxt_addr)
  );

  assign advance = !stall && !halted && !f_halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc    <= '0;
      halted <= 1'b0;
    end else begin
      if (advance) upc <= nxt_addr;
      if (!stall && f_halt) halted <= 1'b1;
    end
  end

  // R2
  jump_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && f_mode == 2'd0) |=> upc == $past(f_next));

  // R3
  flag_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && f_mode == 2'd1) |=> upc[UA_W-1:1] == $past(f_next[UA_W-1:1]));

  // R4
  ophi_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && f_mode == 2'd2) |=>
      (upc[NIB_W-1:0] == $past(ir[IR_W-1 -: NIB_W]) &&
       upc[UA_W-1:NIB_W] == $past(f_next[UA_W-1:NIB_W])));

  // R5
  oplo_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && f_mode == 2'd3) |=>
      (upc[NIB_W-1:0] == $past(ir[NIB_W-1:0]) &&
       upc[UA_W-1:NIB_W] == $past(f_next[UA_W-1:NIB_W])));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(upc) && $stable(halted)));

  // R7
  halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_halt && !stall) |=> (halted && $stable(upc)));

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(upc)));
endmodule

// File: tb/sim_useq_core.sv
`timescale 1ns/1ps
module sim_useq_core;
  import useq_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             stall = 1'b0;
  logic [3:0]       alu_nzvc = '0;
  logic [7:0]       ir = '0;
  logic             cs_we = 1'b0;
  logic [8:0]       cs_waddr = '0;
  logic [37:0]      cs_wdata = '0;
  logic [8:0]       upc;
  logic [37:0]      uword;
  logic             halted;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [37:0] shadow [512];
  logic [8:0]  e_upc;
  logic        e_halt;

  always #2 clk = ~clk;

  useq_core u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .alu_nzvc(alu_nzvc), .ir(ir),
    .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
    .upc(upc), .uword(uword), .halted(halted)
  );

  function automatic logic [37:0] mk(input logic h, input logic [1:0] ts,
                                     input logic [1:0] md, input logic [8:0] na,
                                     input logic [23:0] pl);
    return {h, ts, md, na, pl};
  endfunction

  function automatic logic [8:0] ref_next(input logic [37:0] w, input logic [3:0] f,
                                          input logic [7:0] i);
    logic [8:0] na;
    logic [1:0] md;
    logic [1:0] ts;
    logic       b;
    na = w[32:24];
    md = w[34:33];
    ts = w[36:35];
    b  = f[3 - ts];
    case (md)
      2'd1:    return {na[8:1], b};
      2'd2:    return {na[8:4], i[7:4]};
      2'd3:    return {na[8:4], i[3:0]};
      default: return na;
    endcase
  endfunction

  function automatic logic [37:0] rnd_word();
    return mk(1'b0, 2'($urandom), 2'($urandom), 9'($urandom), 24'($urandom));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [37:0] act,
                       input logic [37:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle, entered and left at a falling edge
  task automatic cyc(input logic st, input logic [3:0] f, input logic [7:0] i,
                     input logic we, input logic [8:0] wa, input logic [37:0] wd);
    logic [37:0] w;
    string tag;
    stall = st; alu_nzvc = f; ir = i;
    cs_we = we; cs_waddr = wa; cs_wdata = wd;
    w = shadow[e_upc];
    if (st)                  tag = "R6";
    else if (e_halt || w[37]) tag = "R7";
    else case (w[34:33])
      2'd0: tag = "R2";
      2'd1: tag = "R3";
      2'd2: tag = "R4";
      default: tag = "R5";
    endcase
    if (!st && !e_halt && !w[37]) e_upc = ref_next(w, f, i);
    if (!st && w[37]) e_halt = 1'b1;
    if (we) shadow[wa] = wd;
    @(posedge clk);
    @(negedge clk);
    cs_we = 1'b0;
    check(upc == e_upc, tag, 38'(upc), 38'(e_upc));
    check(uword == shadow[e_upc], "R8", uword, shadow[e_upc]);
    check(halted == e_halt, (st ? "R6" : "R7"), 38'(halted), 38'(e_halt));
  endtask

  // rewrite the word under the counter while stalled
  task automatic place(input logic [37:0] wd);
    cyc(1'b1, 4'h0, 8'h00, 1'b1, e_upc, wd);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    e_upc = '0;
    e_halt = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1
    check(upc == 9'd0, "R1", 38'(upc), 38'd0);
    check(halted == 1'b0, "R1", 38'(halted), 38'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20260));
    rst_n = 1'b0;
    e_upc = '0;
    e_halt = 1'b0;
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      shadow[a] = rnd_word();
      cs_we = 1'b1; cs_waddr = 9'(a); cs_wdata = shadow[a];
    end
    @(negedge clk);
    cs_we = 1'b0;
    do_reset();
    check(upc == 9'd0, "R1", 38'(upc), 38'd0);

    // constrained random run (R2..R6, R8)
    for (int k = 0; k < 3000; k++) begin
      logic st;
      logic wr;
      st = ($urandom % 5) == 0;
      wr = ($urandom % 10) == 0;
      cyc(st, 4'($urandom), 8'($urandom), wr, 9'($urandom), rnd_word());
    end

    // R4 upper nibble dispatch
    place(mk(1'b0, 2'd0, 2'd2, 9'h1F0, 24'h111111));
    cyc(1'b0, 4'hF, 8'hA5, 1'b0, 9'd0, '0);
    check(upc == 9'h1FA, "R4", 38'(upc), 38'h1FA);

    // R5 lower nibble dispatch
    place(mk(1'b0, 2'd1, 2'd3, 9'h00F, 24'h222222));
    cyc(1'b0, 4'h0, 8'h5A, 1'b0, 9'd0, '0);
    check(upc == 9'h00A, "R5", 38'(upc), 38'h00A);

    // R3 each flag selects its own bit
    for (int t = 0; t < 4; t++) begin
      logic [3:0] oh;
      oh = 4'b1000 >> t;
      place(mk(1'b0, 2'(t), 2'd1, 9'h0AB, 24'h333333));
      cyc(1'b0, oh, 8'h00, 1'b0, 9'd0, '0);
      check(upc == 9'h0AB, "R3", 38'(upc), 38'h0AB);
      place(mk(1'b0, 2'(t), 2'd1, 9'h0AB, 24'h333333));
      cyc(1'b0, ~oh, 8'h00, 1'b0, 9'd0, '0);
      check(upc == 9'h0AA, "R3", 38'(upc), 38'h0AA);
    end

    // R2 flags and ir have no effect
    place(mk(1'b0, 2'd3, 2'd0, 9'h1FF, 24'h444444));
    cyc(1'b0, 4'hF, 8'hFF, 1'b0, 9'd0, '0);
    check(upc == 9'h1FF, "R2", 38'(upc), 38'h1FF);

    // R7 halt word, then rewrite it: still halted and frozen
    place(mk(1'b1, 2'd0, 2'd0, 9'h055, 24'h555555));
    cyc(1'b0, 4'h0, 8'h00, 1'b0, 9'd0, '0);
    check(halted == 1'b1, "R7", 38'(halted), 38'd1);
    check(upc == 9'h1FF, "R7", 38'(upc), 38'h1FF);
    cyc(1'b0, 4'h0, 8'h00, 1'b1, e_upc, mk(1'b0, 2'd0, 2'd0, 9'h000, 24'h0));
    for (int k = 0; k < 5; k++) cyc(1'b0, 4'($urandom), 8'($urandom), 1'b0, 9'd0, '0);
    check(upc == 9'h1FF, "R7", 38'(upc), 38'h1FF);

    // R1 reset clears halt
    do_reset();
    cyc(1'b0, 4'h3, 8'h3C, 1'b0, 9'd0, '0);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule